// File: doc/BRIEF.md
# NMI Edge Latch and Pending Controller

This block turns an asynchronous non-maskable interrupt pin into a clean request for a processor core. The pin goes through a flop synchronizer, and only a low-to-high transition counts as an event. A small state machine tracks the handler. The request is raised and then dropped when the core takes it. While the handler runs, one further event is remembered. That event is released as a new request when the core signals return-from-interrupt. The request always carries the fixed internal vector 2, and no acknowledge handshake is issued beyond the single take pulse.

At the first clock after reset is released, a strap line is captured. A low strap means the local interrupt controller is disabled. In that mode the pin acts as a plain local interrupt line: its synchronized level appears on `lint_o` and it never raises a request.

The state machine has four states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Nothing requested and no handler running |
| `ST_REQ` | A request is raised |
| `ST_SERV` | A handler is running |
| `ST_SERV_PEND` | A handler is running and one event is held |

Its transitions are:

| From | Condition | To |
|---|---|---|
| `ST_IDLE` | an event arrives | `ST_REQ` |
| `ST_REQ` | take arrives | `ST_SERV` |
| `ST_REQ` | take and an event arrive in the same cycle | `ST_SERV_PEND` |
| `ST_SERV` | an event arrives | `ST_SERV_PEND` |
| `ST_SERV` | return arrives | `ST_IDLE` |
| `ST_SERV` | return and an event arrive in the same cycle | `ST_REQ` |
| `ST_SERV_PEND` | return arrives | `ST_REQ` |

Every other combination stays in the current state.

Top module: `nmi_pend_ctrl`

## Requirements
- R1: A rising edge on the pin raises one request. Holding the pin high raises no further request.
- R2: `vec_o` is always 8'd2.
- R3: A take pulse while the request is raised drops `irq_o` one cycle later. No other handshake is needed.
- R4: An edge during service raises nothing until the return pulse. `irq_o` then rises in the cycle after the return pulse.
- R5: At most one event is held. Two edges during one service give exactly one request after the return pulse, and none after the next return pulse.
- R6: `ctl_en_o` equals the strap value captured on the first clock after reset is released (1 means enabled).
- R7: With `ctl_en_o` low, `irq_o` stays 0 and `lint_o` follows the synchronized pin. With `ctl_en_o` high, `lint_o` is 0.
- R8: Reset clears the request, the held event and the in-service condition.
- R9: An edge in the same cycle as a take pulse is held as pending.
- R10: A take pulse with no request raised, and a return pulse with no handler running, have no effect.
- R11: `irq_o` rises on the third clock edge after the pin rises (two synchronizer stages plus the state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nmi_pin_i | input | 1 | Asynchronous interrupt pin |
| strap_i | input | 1 | Controller-enable strap, captured after reset |
| take_i | input | 1 | Core takes the request (pulse) |
| iret_i | input | 1 | Core returns from the handler (pulse) |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 8 | Fixed vector, 2 |
| ctl_en_o | output | 1 | Captured controller-enable flag |
| lint_o | output | 1 | Synchronized pin level when the controller is disabled |

## Verification
A wrong internal state can show up in three ways at the ports:
- A lost held event shows as `irq_o` staying low in the cycle after a return pulse.
- A second held event shows as an extra request after the next return pulse.
- An in-service condition that was not cleared shows as a fresh edge raising nothing within three cycles.

Every such fault becomes visible at most three clock edges after the stimulus that exposes it. The directed scenarios place the pulses so that each one lands in a chosen state of the state machine.

// File: rtl/nmi_pkg.sv
package nmi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_REQ       = 2'd1,
        ST_SERV      = 2'd2,
        ST_SERV_PEND = 2'd3
    } nmi_state_e;
endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic lvl,
    output logic rise
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain[0] <= pin;
            prev     <= chain[TOP];
        end
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    assign lvl  = chain[TOP];
    assign rise = chain[TOP] & ~prev;
endmodule

// File: rtl/nmi_strap_cap.sv
module nmi_strap_cap (
    input  logic clk,
    input  logic rst_n,
    input  logic strap,
    output logic en
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b1;
            en    <= 1'b0;
        end else if (armed) begin
            armed <= 1'b0;
            en    <= strap;
        end
    end
endmodule

// File: rtl/nmi_pend_fsm.sv
module nmi_pend_fsm
    import nmi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt,
    input  logic       take,
    input  logic       iret,
    output logic       req,
    output nmi_state_e state
);
    nmi_state_e next;

    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE: begin
                if (evt) next = ST_REQ;
            end
            ST_REQ: begin
                if (take) next = evt ? ST_SERV_PEND : ST_SERV;
            end
            ST_SERV: begin
                if (iret) next = evt ? ST_REQ : ST_IDLE;
                else if (evt) next = ST_SERV_PEND;
            end
            ST_SERV_PEND: begin
                if (iret) next = ST_REQ;
            end
            default: next = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req <= 1'b0;
        else        req <= (next == ST_REQ);
    end
endmodule

// File: rtl/nmi_pend_ctrl.sv
module nmi_pend_ctrl
    import nmi_pkg::*;
#(
    parameter int VEC_W       = 8,
    parameter int VEC_VAL     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             nmi_pin_i,
    input  logic             strap_i,
    input  logic             take_i,
    input  logic             iret_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             ctl_en_o,
    output logic             lint_o
);
    logic       pin_lvl;
    logic       pin_rise;
    logic       evt_gated;
    nmi_state_e fsm_state;

    nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk_i),
        .rst_n(rst_ni),
        .pin  (nmi_pin_i),
        .lvl  (pin_lvl),
        .rise (pin_rise)
    );

    nmi_strap_cap u_strap (
        .clk  (clk_i),
        .rst_n(rst_ni),
        .strap(strap_i),
        .en   (ctl_en_o)
    );

    assign evt_gated = pin_rise & ctl_en_o;

    nmi_pend_fsm u_fsm (
        .clk  (clk_i),
        .rst_n(rst_ni),
        .evt  (evt_gated),
        .take (take_i),
        .iret (iret_i),
        .req  (irq_o),
        .state(fsm_state)
    );

    assign vec_o  = VEC_W'(VEC_VAL);
    assign lint_o = ctl_en_o ? 1'b0 : pin_lvl;
endmodule

// File: rtl/nmi_pend_chk.sv
module nmi_pend_chk
    import nmi_pkg::*;
#(
    parameter int VEC_W   = 8,
    parameter int VEC_VAL = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             take,
    input logic             iret,
    input logic             ctl_en,
    input logic             evt,
    input nmi_state_e       state,
    input logic [VEC_W-1:0] vec
);
    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(evt) || $past(iret))); // R1
    AST_VEC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vec == VEC_W'(VEC_VAL))); // R2
    AST_TAKE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && take) |=> !irq); // R3
    AST_RFI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERV_PEND && iret) |=> irq); // R4
    AST_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SERV_PEND) |-> !irq); // R5
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> !irq); // R7
endmodule

bind nmi_pend_ctrl nmi_pend_chk #(.VEC_W(VEC_W), .VEC_VAL(VEC_VAL)) u_chk (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .irq   (irq_o),
    .take  (take_i),
    .iret  (iret_i),
    .ctl_en(ctl_en_o),
    .evt   (evt_gated),
    .state (fsm_state),
    .vec   (vec_o)
);

// File: tb/nmi_pend_ctrl_test.sv
module nmi_pend_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       strap = 1'b1;
    logic       take = 1'b0;
    logic       iret = 1'b0;
    logic       irq;
    logic [7:0] vec;
    logic       ctl_en;
    logic       lint;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nmi_pend_ctrl uut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .nmi_pin_i(pin),
        .strap_i  (strap),
        .take_i   (take),
        .iret_i   (iret),
        .irq_o    (irq),
        .vec_o    (vec),
        .ctl_en_o (ctl_en),
        .lint_o   (lint)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0; pin = 1'b0; take = 1'b0; iret = 1'b0; strap = s;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
    endtask

    task automatic pulse_take;
        @(negedge clk); take = 1'b1;
        @(negedge clk); take = 1'b0;
    endtask

    task automatic pulse_iret;
        @(negedge clk); iret = 1'b1;
        @(negedge clk); iret = 1'b0;
    endtask

    task automatic edge_pin;
        @(negedge clk); pin = 1'b1;
        wait_n(4);
        pin = 1'b0;
        wait_n(4);
    endtask

    task automatic t_reset;
        do_reset(1'b1);
        check(irq == 1'b0, "R8 reset irq", irq, 0);
        check(ctl_en == 1'b1, "R6 strap high", ctl_en, 1);
        check(lint == 1'b0, "R7 lint off when enabled", lint, 0);
        check(vec == 8'd2, "R2 vector", vec, 2);
    endtask

    task automatic t_latency;
        @(negedge clk); pin = 1'b1;
        wait_n(2);
        check(irq == 1'b0, "R11 not before third edge", irq, 0);
        wait_n(1);
        check(irq == 1'b1, "R11 request on third edge", irq, 1);
        check(vec == 8'd2, "R2 vector with request", vec, 2);
        wait_n(8);
        check(irq == 1'b1, "R1 request holds until take", irq, 1);
        pulse_take;
        check(irq == 1'b0, "R3 take drops request", irq, 0);
        wait_n(8);
        check(irq == 1'b0, "R1 held level raises nothing", irq, 0);
        pulse_iret;
        wait_n(5);
        check(irq == 1'b0, "R1 level after return raises nothing", irq, 0);
        pin = 1'b0;
        wait_n(4);
    endtask

    task automatic t_nested;
        edge_pin;
        pulse_take;
        edge_pin;
        check(irq == 1'b0, "R4 held during service", irq, 0);
        pulse_iret;
        check(irq == 1'b1, "R4 released after return", irq, 1);
        pulse_take;
        pulse_iret;
        wait_n(4);
        check(irq == 1'b0, "R4 cleanup", irq, 0);
    endtask

    task automatic t_single_pend;
        edge_pin;
        pulse_take;
        edge_pin;
        edge_pin;
        edge_pin;
        pulse_iret;
        check(irq == 1'b1, "R5 one request after return", irq, 1);
        pulse_take;
        pulse_iret;
        wait_n(6);
        check(irq == 1'b0, "R5 no second held event", irq, 0);
    endtask

    task automatic t_same_cycle;
        edge_pin;
        check(irq == 1'b1, "R9 precondition", irq, 1);
        @(negedge clk); pin = 1'b1;
        wait_n(2);
        take = 1'b1;
        @(negedge clk); take = 1'b0;
        check(irq == 1'b0, "R3 take with edge", irq, 0);
        wait_n(3);
        pin = 1'b0;
        pulse_iret;
        check(irq == 1'b1, "R9 same-cycle edge pending", irq, 1);
        pulse_take;
        pulse_iret;
        wait_n(4);
    endtask

    task automatic t_ignored;
        pulse_take;
        pulse_iret;
        wait_n(3);
        check(irq == 1'b0, "R10 idle pulses no request", irq, 0);
        edge_pin;
        pulse_iret;
        check(irq == 1'b1, "R10 return while requested ignored", irq, 1);
        pulse_take;
        pulse_take;
        edge_pin;
        check(irq == 1'b0, "R10 still in service", irq, 0);
        pulse_iret;
        check(irq == 1'b1, "R10 pending kept", irq, 1);
        pulse_take;
        pulse_iret;
        wait_n(4);
    endtask

    task automatic t_reset_mid;
        edge_pin;
        pulse_take;
        edge_pin;
        do_reset(1'b1);
        check(irq == 1'b0, "R8 reset mid-service irq", irq, 0);
        pulse_iret;
        wait_n(3);
        check(irq == 1'b0, "R8 pending cleared", irq, 0);
        edge_pin;
        check(irq == 1'b1, "R8 service cleared", irq, 1);
        pulse_take;
        pulse_iret;
    endtask

    task automatic t_disabled;
        do_reset(1'b0);
        check(ctl_en == 1'b0, "R6 strap low", ctl_en, 0);
        @(negedge clk); pin = 1'b1;
        wait_n(5);
        check(lint == 1'b1, "R7 lint follows pin", lint, 1);
        check(irq == 1'b0, "R7 no request when disabled", irq, 0);
        pin = 1'b0;
        wait_n(4);
        check(lint == 1'b0, "R7 lint low", lint, 0);
    endtask

    initial begin
        t_reset;
        t_latency;
        t_nested;
        t_single_pend;
        t_same_cycle;
        t_ignored;
        t_reset_mid;
        t_disabled;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule